// File: doc/BRIEF.md
# Latched Event Status Register Set

This block watches a small group of event signals from a monitoring engine, such as a bit-error-rate tester, and shows them to a host through three byte-wide registers at neighbouring addresses. The first register returns the present level of each signal. The second holds a sticky flag for each signal, and that flag is set when the signal makes a qualifying transition. The third holds the interrupt enables. The real-time bit, the latched bit and the enable bit of one signal all sit at the same bit position in the three registers.

Each latched bit has its own fixed transition rule. Bits 1, 2 and 3 latch only on a rising edge. Bits 0, 4 and 5 latch on a change in either direction. The host clears a latched flag by writing 1 to its position, and a cleared flag stays clear until a new transition arrives. An active-low, registered interrupt output combines the enabled latched flags with an interrupt request from outside the block. Event inputs pass through a two-stage synchronizer before edge detection. The host port is synchronous, and read data appears one clock after the address is presented.

Top module: `evt_status_regs`

## Requirements
- R1: The register at address 0 returns the synchronized level of inputs 0, 1, 2, 4 and 5 in the same bit positions. Bits 3, 6 and 7 read 0. Address 3 reads 0. Read data is registered and appears one clock after the address.
- R2: Latched register (address 1), bit i follows input i. Bits 1, 2 and 3 set only on a low-to-high change of their input. Bits 0, 4 and 5 set on a change in either direction. Bits 6 and 7 read 0.
- R3: Writing 1 to a bit of the latched register clears that bit. Writing 0 leaves it unchanged.
- R4: A cleared latched bit stays 0 while its input holds its level, including the active level, until a new qualifying transition occurs.
- R5: If a write-1 clear and a new qualifying edge hit the same bit in the same cycle, the bit ends at 1.
- R6: Enable register (address 2): bits 0 to 3 can be written and read back. Bits 4 to 7 always read 0.
- R7: `irq_no` goes low one clock after any of latched bits 0 to 3 is 1 together with its enable bit. Latched bits 4 and 5 never pull it low.
- R8: `ext_irq_i` high drives `irq_no` low one clock later, whatever the latched and enable state.
- R9: After reset, all latched bits and all enable bits are 0 and `irq_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 6 | Monitored event levels, asynchronous |
| ext_irq_i | input | 1 | Interrupt request from another source, active high |
| addr_i | input | 2 | Register address: 0 real-time, 1 latched, 2 enable |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench targets the edge rules one bit at a time. A falling edge on a rise-only bit must leave its flag at 0, so a design that treats every bit as either-edge would set flags it should not. It clears a flag while the input is still held high. A design that sets flags from the input level instead of its edge would set the flag again at once. It also lines up a write-1 clear with the cycle the edge is detected. A design that lets the clear win would lose that event. Finally, it raises the status-only bits 4 and 5 with every enable written to 1. A design that forgot those bits have no enable would raise the interrupt anyway.

// File: rtl/status_pkg.sv
package status_pkg;
  typedef enum logic [1:0] {EDGE_RISE, EDGE_FALL, EDGE_ANY} edge_rule_e;

  localparam int unsigned NUM_EVT = 6;
  localparam int unsigned NUM_EN  = 4;
  localparam logic [7:0]  RT_MASK = 8'b0011_0111;

  localparam logic [1:0] ADR_RT  = 2'd0;
  localparam logic [1:0] ADR_LAT = 2'd1;
  localparam logic [1:0] ADR_EN  = 2'd2;

  function automatic edge_rule_e bit_rule(input int unsigned idx);
    if (idx >= 1 && idx <= 3) return EDGE_RISE;
    return EDGE_ANY;
  endfunction
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/edge_latch.sv
module edge_latch
  import status_pkg::*;
#(
  parameter edge_rule_e RULE = EDGE_ANY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  output logic q_o
);
  logic prev_q, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  generate
    if (RULE == EDGE_RISE) begin : g_rise
      assign hit = lvl_i & ~prev_q;
    end else if (RULE == EDGE_FALL) begin : g_fall
      assign hit = ~lvl_i & prev_q;
    end else begin : g_any
      assign hit = lvl_i ^ prev_q;
    end
  endgenerate

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (hit)   q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> q_o);
  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !q_o);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !hit) |=> $stable(q_o));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lat_i,
  input  logic [N-1:0] en_i,
  input  logic         ext_i,
  output logic         irq_no
);
  logic req;
  assign req = (|(lat_i & en_i)) | ext_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= ~req;
  end

  a_r7_irq_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(lat_i & en_i)) |=> !irq_no);
  a_r8_ext_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_i |=> !irq_no);
  a_r7_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_i && (lat_i & en_i) == '0) |=> irq_no);
endmodule

// File: rtl/evt_status_regs.sv
module evt_status_regs
  import status_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic              ext_irq_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_no
);
  localparam int unsigned PAD_LAT = DATA_W - NUM_EVT;
  localparam int unsigned PAD_EN  = DATA_W - NUM_EN;

  logic [NUM_EVT-1:0] lvl, lat, clr;
  logic [NUM_EN-1:0]  en_q;
  logic [DATA_W-1:0]  rd_mux;

  evt_sync #(.WIDTH(NUM_EVT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(evt_i), .q_o(lvl)
  );

  assign clr = (wr_en_i && addr_i == ADR_LAT) ? wdata_i[NUM_EVT-1:0] : '0;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_lat
    edge_latch #(.RULE(bit_rule(i))) u_lat (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl[i]), .clr_i(clr[i]), .q_o(lat[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          en_q <= '0;
    else if (wr_en_i && addr_i == ADR_EN) en_q <= wdata_i[NUM_EN-1:0];
  end

  irq_combine #(.N(NUM_EN)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .lat_i(lat[NUM_EN-1:0]), .en_i(en_q),
    .ext_i(ext_irq_i), .irq_no(irq_no)
  );

  always_comb begin
    unique case (addr_i)
      ADR_RT:  rd_mux = {{PAD_LAT{1'b0}}, lvl} & RT_MASK;
      ADR_LAT: rd_mux = {{PAD_LAT{1'b0}}, lat};
      ADR_EN:  rd_mux = {{PAD_EN{1'b0}}, en_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_mux;
  end

  a_r9_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (irq_no && lat == '0 && en_q == '0));
  a_r1_rt_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADR_RT) |=> (rdata_o[3] == 1'b0 && rdata_o[7:6] == 2'b00));
endmodule

// File: tb/evt_status_regs_test.sv
`timescale 1ns/1ps
module evt_status_regs_test;
  logic       clk = 0, rst_ni = 0;
  logic [5:0] evt = '0;
  logic       ext = 0, wr_en = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       irq_no;
  int checks = 0, errors = 0;

  localparam logic [5:0] RISE_M = 6'b001110;
  localparam logic [5:0] ANY_M  = 6'b110001;

  logic [5:0] m_lat = '0;
  logic [3:0] m_en = '0;

  always #2.5 clk = ~clk;

  evt_status_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .ext_irq_i(ext), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .irq_no(irq_no)
  );

  function automatic logic [5:0] hits(input logic [5:0] o, input logic [5:0] n);
    return (n & ~o & RISE_M) | ((n ^ o) & ANY_M);
  endfunction
  function automatic logic [7:0] exp_rt(input logic [5:0] e);
    return {2'b00, e} & 8'b0011_0111;
  endfunction
  function automatic logic exp_irq(input logic [5:0] l, input logic [3:0] en, input logic x);
    return !((|(l[3:0] & en)) || x);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_evt(input logic [5:0] n);
    @(negedge clk);
    m_lat |= hits(evt, n);
    evt = n;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    rd(2'd0, d); check({"R1 rt ", tag}, d, exp_rt(evt));
    rd(2'd1, d); check({"R2 lat ", tag}, d, {2'b00, m_lat});
    rd(2'd2, d); check({"R6 en ", tag}, d, {4'h0, m_en});
    check({"R7 irq ", tag}, {7'd0, irq_no}, {7'd0, exp_irq(m_lat, m_en, ext)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    // R9 reset state
    check("R9 irq", {7'd0, irq_no}, 8'h01);
    rd(2'd1, d); check("R9 lat", d, 8'h00);
    rd(2'd2, d); check("R9 en", d, 8'h00);
    rd(2'd3, d); check("R1 addr3", d, 8'h00);

    // R2 fall on rise-only bit 1 must not latch
    set_evt(6'b000010); wr(2'd1, 8'hff); m_lat = '0;
    set_evt(6'b000000);
    rd(2'd1, d); check("R2 fall rise-only", d, 8'h00);

    // R4 clear while still high
    set_evt(6'b000010);
    rd(2'd1, d); check("R2 rise bit1", d, 8'h02);
    wr(2'd1, 8'h02); m_lat = '0;
    repeat (4) @(negedge clk);
    rd(2'd1, d); check("R4 stays clear", d, 8'h00);

    // R3 write 0 keeps; bit0 either edge
    set_evt(6'b000011);
    wr(2'd1, 8'h00);
    rd(2'd1, d); check("R3 write0 keeps", d, 8'h01);
    wr(2'd1, 8'h01); m_lat = '0;
    set_evt(6'b000000);
    rd(2'd1, d); check("R2 fall bit0", d, 8'h01);
    wr(2'd1, 8'hff); m_lat = '0;

    // R5 set wins over same-cycle clear on bit2
    @(negedge clk); evt = 6'b000100;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 2'd1; wdata = 8'h04; wr_en = 1;
    @(negedge clk); wr_en = 0;
    m_lat = 6'b000100;
    repeat (3) @(negedge clk);
    rd(2'd1, d); check("R5 set wins", d, 8'h04);
    wr(2'd1, 8'hff); m_lat = '0;

    // R7 status-only bits never interrupt
    wr(2'd2, 8'hff); m_en = 4'hf;
    rd(2'd2, d); check("R6 en upper zero", d, 8'h0f);
    set_evt(6'b110100);
    check("R7 bits4-5 no irq", {7'd0, irq_no}, 8'h01);
    rd(2'd1, d); check("R2 bits4-5 latched", d, 8'h30);

    // R8 external source
    @(negedge clk); ext = 1; @(negedge clk);
    check("R8 ext irq", {7'd0, irq_no}, 8'h00);
    @(negedge clk); ext = 0; @(negedge clk);
    check("R8 ext release", {7'd0, irq_no}, 8'h01);

    // random phase
    for (int it = 0; it < 300; it++) begin
      int sel = $urandom_range(0, 3);
      case (sel)
        0: set_evt(6'($urandom));
        1: begin logic [7:0] c = 8'($urandom); wr(2'd1, c); m_lat &= ~c[5:0]; end
        2: begin logic [7:0] e = 8'($urandom); wr(2'd2, e); m_en = e[3:0]; end
        default: begin @(negedge clk); ext = 1'($urandom); end
      endcase
      repeat (2) @(negedge clk);
      check_all("rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule